// File: doc/BRIEF.md
# Paged Strobe Controller for Asynchronous 256K x 16 DRAM

This block sits between a synchronous host and an asynchronous 256K x 16 DRAM with extended-data-out page mode. The host hands it one word access at a time over a valid/ready handshake. Each access carries an 18-bit word address, 16-bit write data, two byte enables and a write flag. The controller turns it into a timed sequence of row strobe, per-byte column strobes, write enable and output enable. It also drives a 9-bit multiplexed address and a data bus that it only drives during writes.

The controller leaves a row open after an access. A later access to the same row then skips the row phase and issues only a new column strobe. Reads and writes may be mixed while the row stays open. A request to another row closes the page first. An asserted refresh request also closes the page and holds off new work, so that an outside agent can take the device. All minimum strobe times are counted in clock cycles and set by parameters: row-to-column delay, column access, row active, row precharge and column precharge.

Top module: `edo_dram_ctrl`

## Requirements
- R1: After reset the row strobe, both column strobes, write enable and output enable are high (inactive). The data bus is not driven, `rsp_valid` is low, and `req_ready` is high while `refresh_req` is low.
- R2: The row half `req_addr[17:9]` is on `dram_addr` when the row strobe falls. The column half `req_addr[8:0]` is on `dram_addr` when the column strobes fall.
- R3: `dram_cas_n[0]` serves data bits 7:0 and `dram_cas_n[1]` serves bits 15:8. A column strobe goes low only when its byte enable is set. A write changes only the enabled bytes. A read returns zero in the bytes whose enable is clear.
- R4: During a write the column strobes fall with `dram_we_n` low, `dram_oe_n` high and the write data already driven, with `dram_dq_oe` high.
- R5: During a read `dram_we_n` is high and `dram_oe_n` is low. The bus is sampled T_CAC cycles after the column strobe falls. The result appears for one cycle on `rsp_valid`/`rsp_rdata`. Results come in request order.
- R6: The row strobe stays low for at least T_RAS cycles.
- R7: The row strobe stays high for at least T_RP cycles before it falls again.
- R8: Between two column accesses in one open row, the column strobes stay high for at least T_CP cycles.
- R9: A request to the open row is served without another row strobe cycle.
- R10: A request to a different row raises the row strobe, waits out precharge, and opens the new row.
- R11: While `refresh_req` is high, `req_ready` is low, and an open row is closed (row strobe returns high).
- R12: The data bus is driven only while a write column strobe is active.
- R13: The column strobes are never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted this cycle when valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address, row in upper 9 bits |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 0 = low byte |
| refresh_req | input | 1 | Close open row and hold off requests |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, disabled bytes zero |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 2 | Column strobes per byte, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 9 | Multiplexed row/column address |
| dram_dq_out | output | 16 | Data driven to the device |
| dram_dq_oe | output | 1 | Drive enable for dram_dq_out |
| dram_dq_in | input | 16 | Data returned by the device |

## Verification
The assertions assume that every request has at least one byte enable set. They also assume the request fields stay stable while `req_valid` waits for `req_ready`. The driver task only issues nonzero enables and holds its fields until the acceptance edge. The timing assertions also take for granted that the device returns read data within T_CAC cycles of the column strobe. The bench device model presents data one cycle after it sees the column strobe fall, which stays within that bound at the default setting.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RCD,
    ST_CAS,
    ST_PAGE,
    ST_CLOSE
  } edo_state_e;

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/edo_timer.sv
module edo_timer #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);
endmodule

// File: rtl/edo_open_row.sv
module edo_open_row #(
  parameter int ROW_W = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_open,
  input  logic [ROW_W-1:0] set_row,
  input  logic             clear,
  input  logic [ROW_W-1:0] probe_row,
  output logic             is_open,
  output logic             hit
);
  logic [ROW_W-1:0] row_q;
  logic             open_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      row_q  <= '0;
    end else if (set_open) begin
      open_q <= 1'b1;
      row_q  <= set_row;
    end else if (clear) begin
      open_q <= 1'b0;
    end
  end

  assign is_open = open_q;
  assign hit     = open_q && (row_q == probe_row);
endmodule

// File: rtl/edo_dram_ctrl.sv
module edo_dram_ctrl
  import edo_pkg::*;
#(
  parameter int MUX_W  = 9,
  parameter int DATA_W = 16,
  parameter int T_RCD  = 2,
  parameter int T_CAC  = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 3,
  parameter int T_CP   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_we,
  input  logic [2*MUX_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  input  logic                   refresh_req,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_rdata,
  output logic                   dram_ras_n,
  output logic [DATA_W/8-1:0]    dram_cas_n,
  output logic                   dram_we_n,
  output logic                   dram_oe_n,
  output logic [MUX_W-1:0]       dram_addr,
  output logic [DATA_W-1:0]      dram_dq_out,
  output logic                   dram_dq_oe,
  input  logic [DATA_W-1:0]      dram_dq_in
);
  localparam int LANES = DATA_W / 8;
  localparam int AW    = 2 * MUX_W;
  localparam int TMAX  = max_of(max_of(max_of(T_RCD, T_CAC), max_of(T_RAS, T_RP)), T_CP);
  localparam int TW    = max_of($clog2(TMAX + 1), 1);

  edo_state_e state_q;

  logic              ras_n_q, we_n_q, oe_n_q, dq_oe_q, rsp_valid_q;
  logic [LANES-1:0]  cas_n_q;
  logic [MUX_W-1:0]  addr_q;
  logic [DATA_W-1:0] dq_out_q, rsp_rdata_q;

  logic              we_q;
  logic [LANES-1:0]  be_q;
  logic [DATA_W-1:0] wdata_q;
  logic [MUX_W-1:0]  col_q;

  logic [MUX_W-1:0]  req_row, req_col;
  logic              accept, launch, from_host;
  logic              l_we;
  logic [LANES-1:0]  l_be;
  logic [MUX_W-1:0]  l_col;
  logic [DATA_W-1:0] l_wdata;
  logic [DATA_W-1:0] rd_masked;

  logic              phase_load, phase_done;
  logic [TW-1:0]     phase_val;
  logic              tras_load, tras_done;
  logic              rp_load, rp_done;
  logic              cp_load, cp_done;
  logic              page_open, page_hit;

  assign req_row = req_addr[AW-1:MUX_W];
  assign req_col = req_addr[MUX_W-1:0];

  assign req_ready = !refresh_req &&
                     (((state_q == ST_IDLE) && rp_done) ||
                      ((state_q == ST_PAGE) && cp_done && page_hit));
  assign accept    = req_valid && req_ready;

  // column launch: from the latched request after the row delay, or
  // straight from the host on an open-row hit
  assign from_host = (state_q == ST_PAGE);
  assign launch    = ((state_q == ST_RCD) && phase_done) || (from_host && accept);
  assign l_we      = from_host ? req_we    : we_q;
  assign l_be      = from_host ? req_be    : be_q;
  assign l_col     = from_host ? req_col   : col_q;
  assign l_wdata   = from_host ? req_wdata : wdata_q;

  assign phase_load = ((state_q == ST_IDLE) && accept) || launch;
  assign phase_val  = (state_q == ST_IDLE) ? TW'(T_RCD - 1) : TW'(T_CAC - 1);
  assign tras_load  = (state_q == ST_IDLE) && accept;
  assign rp_load    = (state_q == ST_CLOSE) && tras_done;
  assign cp_load    = (state_q == ST_CAS) && phase_done;

  edo_timer #(.W(TW)) u_phase (
    .clk(clk), .rst(rst), .load(phase_load), .val(phase_val), .done(phase_done));
  edo_timer #(.W(TW)) u_tras (
    .clk(clk), .rst(rst), .load(tras_load), .val(TW'(T_RAS - 1)), .done(tras_done));
  edo_timer #(.W(TW)) u_trp (
    .clk(clk), .rst(rst), .load(rp_load), .val(TW'(T_RP - 1)), .done(rp_done));
  edo_timer #(.W(TW)) u_tcp (
    .clk(clk), .rst(rst), .load(cp_load), .val(TW'(T_CP - 1)), .done(cp_done));

  edo_open_row #(.ROW_W(MUX_W)) u_row (
    .clk(clk), .rst(rst),
    .set_open(tras_load), .set_row(req_row),
    .clear(rp_load), .probe_row(req_row),
    .is_open(page_open), .hit(page_hit));

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign rd_masked[l*8 +: 8] = be_q[l] ? dram_dq_in[l*8 +: 8] : 8'h00;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      ras_n_q     <= 1'b1;
      cas_n_q     <= '1;
      we_n_q      <= 1'b1;
      oe_n_q      <= 1'b1;
      dq_oe_q     <= 1'b0;
      dq_out_q    <= '0;
      addr_q      <= '0;
      rsp_valid_q <= 1'b0;
      rsp_rdata_q <= '0;
      we_q        <= 1'b0;
      be_q        <= '0;
      wdata_q     <= '0;
      col_q       <= '0;
    end else begin
      rsp_valid_q <= 1'b0;
      if (accept) begin
        we_q    <= req_we;
        be_q    <= req_be;
        wdata_q <= req_wdata;
        col_q   <= req_col;
      end
      if (launch) begin
        cas_n_q  <= ~l_be;
        addr_q   <= l_col;
        we_n_q   <= ~l_we;
        oe_n_q   <= l_we;
        dq_oe_q  <= l_we;
        dq_out_q <= l_wdata;
      end
      unique case (state_q)
        ST_IDLE: if (accept) begin
          ras_n_q <= 1'b0;
          addr_q  <= req_row;
          state_q <= ST_RCD;
        end
        ST_RCD: if (phase_done) state_q <= ST_CAS;
        ST_CAS: if (phase_done) begin
          cas_n_q <= '1;
          we_n_q  <= 1'b1;
          oe_n_q  <= 1'b1;
          dq_oe_q <= 1'b0;
          if (!we_q) begin
            rsp_valid_q <= 1'b1;
            rsp_rdata_q <= rd_masked;
          end
          state_q <= ST_PAGE;
        end
        ST_PAGE: begin
          if (accept)                                        state_q <= ST_CAS;
          else if (refresh_req || (req_valid && !page_hit))  state_q <= ST_CLOSE;
        end
        ST_CLOSE: if (tras_done) begin
          ras_n_q <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign dram_ras_n  = ras_n_q;
  assign dram_cas_n  = cas_n_q;
  assign dram_we_n   = we_n_q;
  assign dram_oe_n   = oe_n_q;
  assign dram_addr   = addr_q;
  assign dram_dq_out = dq_out_q;
  assign dram_dq_oe  = dq_oe_q;
  assign rsp_valid   = rsp_valid_q;
  assign rsp_rdata   = rsp_rdata_q;

  // R13
  cas_under_ras_chk: assert property (@(posedge clk) disable iff (rst)
    dram_ras_n |-> (&dram_cas_n));

  // R12
  dq_write_only_chk: assert property (@(posedge clk) disable iff (rst)
    dram_dq_oe |-> (!dram_we_n && dram_oe_n && !(&dram_cas_n)));

  // R6
  ras_min_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dram_ras_n) |-> $past(tras_done));

  // R7
  ras_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dram_ras_n) |-> $past(rp_done));

  // R8
  cas_precharge_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(&dram_cas_n) && !(&dram_cas_n)) |-> $past(cp_done));

  // R11
  refresh_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    refresh_req |-> !req_ready);

  // R9
  hit_keeps_row_chk: assert property (@(posedge clk) disable iff (rst)
    ((state_q == ST_PAGE) && accept) |=> (!dram_ras_n && page_open));
endmodule

// File: tb/tb_edo_dram_ctrl.sv
`timescale 1ns/1ps
module tb_edo_dram_ctrl;
  localparam int T_RCD = 2, T_CAC = 2, T_RAS = 6, T_RP = 3, T_CP = 2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_we = 1'b0, refresh_req = 1'b0;
  logic [17:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = 2'b11;
  logic        req_ready, rsp_valid;
  logic [15:0] rsp_rdata;
  logic        dram_ras_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [1:0]  dram_cas_n;
  logic [8:0]  dram_addr;
  logic [15:0] dram_dq_out;
  logic [15:0] dram_dq_in = '0;

  always #2.5 clk = ~clk;

  edo_dram_ctrl #(.T_RCD(T_RCD), .T_CAC(T_CAC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CP(T_CP)) dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .refresh_req(refresh_req), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
    .dram_oe_n(dram_oe_n), .dram_addr(dram_addr), .dram_dq_out(dram_dq_out),
    .dram_dq_oe(dram_dq_oe), .dram_dq_in(dram_dq_in));

  int n_chk = 0, n_fail = 0;
  logic [15:0] dev_mem [int];
  logic [15:0] ref_mem [int];
  logic [15:0] exp_q [$];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] ref_rd(input int i);
    return ref_mem.exists(i) ? ref_mem[i] : 16'h0000;
  endfunction
  function automatic logic [15:0] dev_rd(input int i);
    return dev_mem.exists(i) ? dev_mem[i] : 16'h0000;
  endfunction

  // device model and strobe timing monitor
  logic        p_ras = 1'b1;
  logic [1:0]  p_cas = 2'b11;
  int          ras_lo_n = 0, ras_hi_n = 100, cas_hi_n = 100;
  bit          col_in_row = 1'b0;
  logic [8:0]  row_lat = '0;
  logic [17:0] acc_addr = '0;
  logic [15:0] acc_wdata = '0;
  logic [1:0]  acc_be = '0;
  int          n_ras_fall = 0;
  int          v_r6 = 0, v_r7 = 0, v_r8 = 0, v_r12 = 0, v_r13 = 0;

  always @(posedge clk) begin
    if (!rst) begin
      int idx;
      logic [15:0] w;
      if (dram_ras_n && dram_cas_n != 2'b11) v_r13++;
      if (dram_dq_oe && (dram_we_n || dram_cas_n == 2'b11)) v_r12++;
      if (!dram_ras_n) begin
        if (p_ras) begin
          if (ras_hi_n < T_RP) v_r7++;
          ras_lo_n = 1;
          row_lat = dram_addr;
          col_in_row = 1'b0;
          n_ras_fall++;
          chk(dram_addr == acc_addr[17:9], "R2 row address at row strobe fall", dram_addr, acc_addr[17:9]);
        end else ras_lo_n++;
      end else begin
        if (!p_ras) begin
          if (ras_lo_n < T_RAS) v_r6++;
          ras_hi_n = 1;
        end else ras_hi_n++;
      end
      if (dram_cas_n != 2'b11) begin
        if (p_cas == 2'b11) begin
          if (col_in_row && cas_hi_n < T_CP) v_r8++;
          col_in_row = 1'b1;
          chk(dram_addr == acc_addr[8:0], "R2 column address at column strobe fall", dram_addr, acc_addr[8:0]);
          chk(dram_cas_n == ~acc_be, "R3 strobe lanes follow byte enables", dram_cas_n, ~acc_be);
          idx = int'({row_lat, dram_addr});
          if (!dram_we_n) begin
            chk(dram_dq_oe && dram_oe_n && dram_dq_out == acc_wdata, "R4 write data driven at strobe fall",
                {dram_dq_oe, dram_oe_n, dram_dq_out}, {2'b11, acc_wdata});
            w = dev_rd(idx);
            if (!dram_cas_n[0]) w[7:0]  = dram_dq_out[7:0];
            if (!dram_cas_n[1]) w[15:8] = dram_dq_out[15:8];
            dev_mem[idx] = w;
          end else begin
            chk(!dram_oe_n && !dram_dq_oe, "R5 read has output enable low, bus released",
                {dram_oe_n, dram_dq_oe}, 2'b00);
            dram_dq_in <= dev_rd(idx);
          end
        end
      end else begin
        cas_hi_n = (p_cas == 2'b11) ? cas_hi_n + 1 : 1;
      end
      p_ras = dram_ras_n;
      p_cas = dram_cas_n;
      if (req_valid && req_ready) begin
        acc_addr  = req_addr;
        acc_wdata = req_wdata;
        acc_be    = req_be;
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && rsp_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R5 unexpected read response", rsp_rdata, 0);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R5/R3 read data in order, disabled bytes zero", rsp_rdata, e);
      end
    end
  end

  // driver: computes expectation, then performs the handshake
  task automatic do_req(input bit we, input logic [17:0] a, input logic [15:0] d, input logic [1:0] be);
    int idx;
    logic [15:0] cur;
    idx = int'(a);
    cur = ref_rd(idx);
    if (we) begin
      if (be[0]) cur[7:0]  = d[7:0];
      if (be[1]) cur[15:8] = d[15:8];
      ref_mem[idx] = cur;
    end else exp_q.push_back(cur & {{8{be[1]}}, {8{be[0]}}});
    @(negedge clk);
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d; req_be = be;
    #1;
    while (!req_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  bit finished = 1'b0;

  initial begin
    #(100000 * 5);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    #1;
    // R1 reset state
    chk(dram_ras_n && dram_cas_n == 2'b11 && dram_we_n && dram_oe_n, "R1 strobes idle after reset",
        {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 5'h1f);
    chk(!dram_dq_oe && !rsp_valid && req_ready, "R1 bus released, no response, ready high",
        {dram_dq_oe, rsp_valid, req_ready}, 3'b001);

    // basic write / read, full and byte lanes (R3, R4, R5)
    do_req(1'b1, {9'd5, 9'd3}, 16'hA1B2, 2'b11);
    do_req(1'b0, {9'd5, 9'd3}, 16'h0,    2'b11);
    do_req(1'b1, {9'd5, 9'd4}, 16'h3344, 2'b11);
    do_req(1'b1, {9'd5, 9'd4}, 16'hEE77, 2'b01);
    do_req(1'b0, {9'd5, 9'd4}, 16'h0,    2'b11);
    do_req(1'b0, {9'd5, 9'd4}, 16'h0,    2'b10);
    do_req(1'b1, {9'd5, 9'd3}, 16'h9900, 2'b10);
    do_req(1'b0, {9'd5, 9'd3}, 16'h0,    2'b01);
    do_req(1'b0, {9'd5, 9'd3}, 16'h0,    2'b11);
    idle(4);
    // R9 all of the above stayed in one open row
    chk(n_ras_fall == 1, "R9 same-row requests share one row cycle", n_ras_fall, 1);

    // R10 row miss and return
    base = n_ras_fall;
    do_req(1'b1, {9'd7, 9'd511}, 16'h5A5A, 2'b11);
    do_req(1'b0, {9'd5, 9'd3},   16'h0,    2'b11);
    do_req(1'b0, {9'd7, 9'd511}, 16'h0,    2'b11);
    idle(4);
    chk(n_ras_fall == base + 3, "R10 each row change opens a new row cycle", n_ras_fall, base + 3);

    // R11 refresh closes page and blocks requests
    refresh_req = 1'b1;
    idle(T_RAS + T_RP + 4);
    #1;
    chk(dram_ras_n == 1'b1, "R11 row strobe high during refresh", dram_ras_n, 1);
    chk(req_ready == 1'b0, "R11 ready low during refresh", req_ready, 0);
    refresh_req = 1'b0;
    base = n_ras_fall;
    do_req(1'b0, {9'd7, 9'd511}, 16'h0, 2'b11);
    idle(4);
    chk(n_ras_fall == base + 1, "R11 access after refresh reopens the row", n_ras_fall, base + 1);

    // mixed traffic over three rows
    for (int i = 0; i < 80; i++) begin
      logic [8:0] r, c;
      logic [1:0] be;
      r  = 9'(($urandom % 3) * 37);
      c  = 9'($urandom % 6);
      be = 2'($urandom_range(1, 3));
      do_req(1'($urandom % 2), {r, c}, 16'($urandom), be);
    end
    idle(30);
    chk(exp_q.size() == 0, "R5 every read answered", exp_q.size(), 0);
    chk(v_r6 == 0,  "R6 row strobe active time violations",   v_r6,  0);
    chk(v_r7 == 0,  "R7 row precharge violations",            v_r7,  0);
    chk(v_r8 == 0,  "R8 column precharge violations",         v_r8,  0);
    chk(v_r12 == 0, "R12 bus driven outside a write",         v_r12, 0);
    chk(v_r13 == 0, "R13 column strobe low with row strobe high", v_r13, 0);
    finished = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule